// File: doc/BRIEF.md
# 16-bit Microcode Execute Unit

This block is a single-cycle execute unit for a small 16-bit microcode engine. It accepts one 16-bit instruction word on every clock edge. It decodes the arithmetic, logic, shift and immediate-load instructions and executes them against eight 16-bit general registers. Each instruction retires in the same cycle it is presented. A carry flag is kept between instructions. The most recently written value is held in a result register, and zero and sign flags are derived from it.

Some encodings belong to other engine units, such as memory access, accelerator writes, temp-register transfers and control flow. This unit ignores those words completely. It leaves the registers, the carry flag and the held result untouched, so the words act as no-ops here.

Bit fields below are numbered 15 (MSB) down to 0. "Class field" means bits [13:12].

Top module: `ucode_exec`

## Requirements
- R1: While reset is asserted and after it is released, every register and the carry flag are 0, the held result is 0, the zero output is 1 and the sign output is 0.
- R2: When the class field is 10, bit 11 is 0 and bit 15 is 0, the unit performs a register-register operation chosen by bits [7:6]: 00 AND, 01 OR, 10 ADD, 11 SUB. Bits [2:0] give the left operand, bits [5:3] the right operand and bits [10:8] the destination. The result is written at the next clock edge.
- R3: ADD sets carry when the unsigned sum exceeds 0xFFFF. SUB produces left + (~right & 0xFFFF) + 1 truncated to 16 bits, and its carry is bit 16 of that sum.
- R4: With the layout of R2 but bit 15 set, bits [7:6] = 00, 10 or 11 give AND, ADD or SUB against the constant (bits [5:3] + 1), a value from 1 to 8. The carry rules of R3 apply. Bits [7:6] = 01 in this form is a no-op.
- R5: When the class field is 10, bit 11 is 1 and bit 7 is 0, the unit shifts register bits [2:0] by the amount {bit 15, bits [5:3]} (0 to 15) and writes the result to bits [10:8]. Bit 6 = 0 shifts left and drops the bits that move out. Bit 6 = 1 shifts right logically.
- R6: When the class field is 00, bit 11 is 1 and bit 15 is 0, the unit writes the 8-bit constant in bits [7:0], zero-extended, to register bits [10:8].
- R7: When the class field is 00, bit 11 is 1 and bit 15 is 1, the unit places bits [10:3] in the upper byte of register bits [2:0] and keeps that register's lower byte. The flags reflect the whole 16-bit value.
- R8: When bit 15 is 0, the class field is 10, bit 11 is 1 and bits [7:3] = 11110, the unit writes the 16-bit complement of register bits [2:0] to bits [10:8].
- R9: When bit 15 is 1, the class field is 10, bit 11 is 1 and bits [7:3] = 10110, the unit writes register bits [2:0] plus the carry flag to bits [10:8]. The carry becomes bit 16 of that sum.
- R10: The zero output is 1 exactly when the held result is 0. The sign output equals bit 15 of the held result. The held result is the value written by the latest executing instruction.
- R11: Every other encoding changes no register, no carry and no held result.
- R12: AND, OR, shifts, NOT and both immediate loads leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word executed at the next rising edge |
| last_result | output | 16 | Value written by the most recent executing instruction |
| carry_flag | output | 1 | Carry flag |
| zero_flag | output | 1 | High when last_result is 0 |
| sign_flag | output | 1 | Bit 15 of last_result |

## Verification
The assertions assume that the instruction word is a known value at every rising edge. They do not assume that it belongs to the executing class, because foreign encodings must fall through as no-ops. The bench changes the word only on falling edges and always drives a fully defined pattern. The sweep mixes in encodings that belong to other units, so the no-op paths are exercised under the same timing. Register contents are read back only with an OR of a register with itself, which is itself an instruction defined by the requirements.

// File: rtl/ucx_pkg.sv
package ucx_pkg;

  localparam int unsigned DATA_W  = 16;
  localparam int unsigned REG_NUM = 8;
  localparam int unsigned IDX_W   = $clog2(REG_NUM);
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  typedef enum logic [3:0] {
    OPK_NONE,
    OPK_AND,
    OPK_OR,
    OPK_ADD,
    OPK_SUB,
    OPK_SHL,
    OPK_SHR,
    OPK_LDI,
    OPK_LDHI,
    OPK_INV,
    OPK_ADC
  } op_kind_e;

  typedef struct packed {
    op_kind_e                kind;
    logic [IDX_W-1:0]        dst;
    logic [IDX_W-1:0]        src_a;
    logic [IDX_W-1:0]        src_b;
    logic                    use_imm;
    logic [DATA_W-1:0]       imm;
  } dec_word_t;

  // Full-width add with carry in; the extra top bit is the carry out.
  function automatic logic [DATA_W:0] wide_add(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic              cin);
    wide_add = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  endfunction

  // Subtraction as x + ~y + 1 so the carry means "no borrow".
  function automatic logic [DATA_W:0] wide_sub(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    wide_sub = wide_add(x, ~y, 1'b1);
  endfunction

  function automatic logic [DATA_W-1:0] shift_by(input logic [DATA_W-1:0]  x,
                                                 input logic [SHAMT_W-1:0] amt,
                                                 input logic               go_right);
    shift_by = go_right ? (x >> amt) : (x << amt);
  endfunction

endpackage

// File: rtl/ucx_decoder.sv
module ucx_decoder
  import ucx_pkg::*;
(
  input  logic [15:0] instr,
  output dec_word_t   dec,
  output logic        dec_valid
);

  logic [1:0] cls;
  logic       hi_bit;
  logic       b11;

  assign cls    = instr[13:12];
  assign hi_bit = instr[15];
  assign b11    = instr[11];

  always_comb begin
    dec         = '0;
    dec.kind    = OPK_NONE;
    dec.dst     = instr[10:8];
    dec.src_a   = instr[2:0];
    dec.src_b   = instr[5:3];
    dec.use_imm = 1'b0;
    dec.imm     = '0;
    if (cls == 2'b10) begin
      if (!b11) begin
        if (!hi_bit) begin
          unique case (instr[7:6])
            2'b00:   dec.kind = OPK_AND;
            2'b01:   dec.kind = OPK_OR;
            2'b10:   dec.kind = OPK_ADD;
            default: dec.kind = OPK_SUB;
          endcase
        end else begin
          dec.use_imm = 1'b1;
          dec.imm     = DATA_W'(instr[5:3]) + DATA_W'(1);
          unique case (instr[7:6])
            2'b00:   dec.kind = OPK_AND;
            2'b10:   dec.kind = OPK_ADD;
            2'b11:   dec.kind = OPK_SUB;
            default: dec.kind = OPK_NONE;
          endcase
        end
      end else if (!instr[7]) begin
        dec.imm  = DATA_W'({hi_bit, instr[5:3]});
        dec.kind = instr[6] ? OPK_SHR : OPK_SHL;
      end else if (!hi_bit && instr[6:3] == 4'b1110) begin
        dec.kind = OPK_INV;
      end else if (hi_bit && instr[6:3] == 4'b0110) begin
        dec.kind = OPK_ADC;
      end
    end else if (cls == 2'b00 && b11) begin
      if (!hi_bit) begin
        dec.kind = OPK_LDI;
        dec.imm  = DATA_W'(instr[7:0]);
      end else begin
        dec.kind  = OPK_LDHI;
        dec.dst   = instr[2:0];
        dec.src_a = instr[2:0];
        dec.imm   = {instr[10:3], {(DATA_W-8){1'b0}}};
      end
    end
  end

  assign dec_valid = (dec.kind != OPK_NONE);

endmodule

// File: rtl/ucx_regfile.sv
module ucx_regfile #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned REG_NUM = 8,
  localparam int unsigned IDX_W  = $clog2(REG_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_val_a,
  output logic [DATA_W-1:0] rd_val_b
);

  logic [DATA_W-1:0] regs [REG_NUM];

  for (genvar g = 0; g < REG_NUM; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        regs[g] <= wr_val;
      end
    end
  end

  assign rd_val_a = regs[rd_idx_a];
  assign rd_val_b = regs[rd_idx_b];

endmodule

// File: rtl/ucx_alu.sv
module ucx_alu
  import ucx_pkg::*;
(
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb_reg,
  input  logic [DATA_W-1:0] imm,
  input  logic              use_imm,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_out,
  output logic              carry_we
);

  logic [DATA_W-1:0] opb;
  logic [DATA_W:0]   sum;

  assign opb = use_imm ? imm : opb_reg;

  always_comb begin
    res       = '0;
    carry_out = carry_in;
    carry_we  = 1'b0;
    sum       = '0;
    unique case (kind)
      OPK_AND:  res = opa & opb;
      OPK_OR:   res = opa | opb;
      OPK_ADD: begin
        sum       = wide_add(opa, opb, 1'b0);
        res       = sum[DATA_W-1:0];
        carry_out = sum[DATA_W];
        carry_we  = 1'b1;
      end
      OPK_SUB: begin
        sum       = wide_sub(opa, opb);
        res       = sum[DATA_W-1:0];
        carry_out = sum[DATA_W];
        carry_we  = 1'b1;
      end
      OPK_SHL:  res = shift_by(opa, imm[SHAMT_W-1:0], 1'b0);
      OPK_SHR:  res = shift_by(opa, imm[SHAMT_W-1:0], 1'b1);
      OPK_LDI:  res = imm;
      OPK_LDHI: res = {imm[DATA_W-1:8], opa[7:0]};
      OPK_INV:  res = ~opa;
      OPK_ADC: begin
        sum       = wide_add(opa, '0, carry_in);
        res       = sum[DATA_W-1:0];
        carry_out = sum[DATA_W];
        carry_we  = 1'b1;
      end
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/ucode_exec.sv
module ucode_exec
  import ucx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr,
  output logic [DATA_W-1:0] last_result,
  output logic              carry_flag,
  output logic              zero_flag,
  output logic              sign_flag
);

  dec_word_t         dec;
  logic              wr_en;
  logic [DATA_W-1:0] rd_a;
  logic [DATA_W-1:0] rd_b;
  logic [DATA_W-1:0] wr_data;
  logic              carry_next;
  logic              carry_we;
  logic              carry_q;
  logic [DATA_W-1:0] result_q;

  ucx_decoder u_dec (
    .instr     (instr),
    .dec       (dec),
    .dec_valid (wr_en)
  );

  ucx_regfile #(
    .DATA_W  (DATA_W),
    .REG_NUM (REG_NUM)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (dec.dst),
    .wr_val   (wr_data),
    .rd_idx_a (dec.src_a),
    .rd_idx_b (dec.src_b),
    .rd_val_a (rd_a),
    .rd_val_b (rd_b)
  );

  ucx_alu u_alu (
    .kind      (dec.kind),
    .opa       (rd_a),
    .opb_reg   (rd_b),
    .imm       (dec.imm),
    .use_imm   (dec.use_imm),
    .carry_in  (carry_q),
    .res       (wr_data),
    .carry_out (carry_next),
    .carry_we  (carry_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q  <= 1'b0;
      result_q <= '0;
    end else if (wr_en) begin
      result_q <= wr_data;
      if (carry_we) begin
        carry_q <= carry_next;
      end
    end
  end

  assign last_result = result_q;
  assign carry_flag  = carry_q;
  assign zero_flag   = (result_q == '0);
  assign sign_flag   = result_q[DATA_W-1];

endmodule

// File: rtl/ucode_exec_chk.sv
module ucode_exec_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              carry_we,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] last_result,
  input logic              carry_flag
);

  // R11
  noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !wr_en) |=> ($stable(last_result) && $stable(carry_flag)));

  // R12
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && wr_en && !carry_we) |=> $stable(carry_flag));

  // R10
  result_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && wr_en) |=> (last_result == $past(wr_data)));

  // R3
  carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_we |-> wr_en);

endmodule

bind ucode_exec ucode_exec_chk #(.DATA_W(ucx_pkg::DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .carry_we    (carry_we),
  .wr_data     (wr_data),
  .last_result (last_result),
  .carry_flag  (carry_flag)
);

// File: tb/ucode_exec_tb_top.sv
module ucode_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [15:0] last_result;
  logic        carry_flag, zero_flag, sign_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mreg [8];
  logic        mc;
  logic [15:0] mres;

  always #4 clk = ~clk;

  ucode_exec dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr       (instr),
    .last_result (last_result),
    .carry_flag  (carry_flag),
    .zero_flag   (zero_flag),
    .sign_flag   (sign_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "result", int'(last_result), int'(mres));
    chk(tag, "carry", int'(carry_flag), int'(mc));
    chk("R10", "zero", int'(zero_flag), (mres == 16'h0) ? 1 : 0);
    chk("R10", "sign", int'(sign_flag), int'(mres[15]));
  endtask

  task automatic issue(input logic [15:0] w, input string tag);
    @(negedge clk);
    instr = w;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  function automatic logic [15:0] wrap(input int v);
    return 16'(v % 65536);
  endfunction

  task automatic put(input int d, input int v);
    mreg[d] = wrap(v);
    mres    = wrap(v);
  endtask

  task automatic do_rr(input int op, input int d, input int l, input int r);
    int a, b, s;
    a = int'(mreg[l]);
    b = int'(mreg[r]);
    case (op)
      0: put(d, a & b);
      1: put(d, a | b);
      2: begin s = a + b; mc = (s > 65535); put(d, s); end
      default: begin s = a + (65535 - b) + 1; mc = (s >= 65536); put(d, s); end
    endcase
    issue({1'b0, 1'b0, 2'b10, 1'b0, 3'(d), 2'(op), 3'(r), 3'(l)}, (op < 2) ? "R2" : "R3");
  endtask

  task automatic readback(input int d, input string tag);
    do_rr(1, d, d, d);
    chk(tag, "regval", int'(last_result), int'(mreg[d]));
  endtask

  task automatic do_imm(input int op, input int d, input int l, input int k);
    int a, s;
    a = int'(mreg[l]);
    case (op)
      0: put(d, a & (k + 1));
      2: begin s = a + k + 1; mc = (s > 65535); put(d, s); end
      default: begin s = a + (65535 - (k + 1)) + 1; mc = (s >= 65536); put(d, s); end
    endcase
    issue({1'b1, 1'b0, 2'b10, 1'b0, 3'(d), 2'(op), 3'(k), 3'(l)}, "R4");
  endtask

  task automatic do_shift(input int dir, input int d, input int l, input int amt);
    int a;
    a = int'(mreg[l]);
    if (dir == 0) put(d, (a * (1 << amt)) % 65536);
    else put(d, a / (1 << amt));
    issue({1'(amt >> 3), 1'b0, 2'b10, 1'b1, 3'(d), 1'b0, 1'(dir), 3'(amt), 3'(l)}, "R5");
  endtask

  task automatic do_li(input int d, input int v);
    put(d, v & 255);
    issue({1'b0, 1'b0, 2'b00, 1'b1, 3'(d), 8'(v)}, "R6");
  endtask

  task automatic do_lis(input int d, input int v);
    put(d, (v & 255) * 256 + (int'(mreg[d]) & 255));
    issue({1'b1, 1'b0, 2'b00, 1'b1, 8'(v), 3'(d)}, "R7");
  endtask

  task automatic do_not(input int d, input int s);
    put(d, 65535 - int'(mreg[s]));
    issue({1'b0, 1'b0, 2'b10, 1'b1, 3'(d), 4'b1111, 1'b0, 3'(s)}, "R8");
  endtask

  task automatic do_addc(input int d, input int s);
    int t;
    t = int'(mreg[s]) + int'(mc);
    mc = (t > 65535);
    put(d, t);
    issue({1'b1, 1'b0, 2'b10, 1'b1, 3'(d), 4'b1011, 1'b0, 3'(s)}, "R9");
  endtask

  task automatic seed(input int base);
    int x;
    x = base;
    for (int r = 0; r < 8; r++) begin
      x = (x * 1103 + 12345) % 65521;
      do_li(r, x & 255);
      do_lis(r, (x >> 8) & 255);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] foreign [10];
    foreign[0] = 16'h0000; foreign[1] = 16'h28B3; foreign[2] = 16'hA8F2;
    foreign[3] = 16'h28F8; foreign[4] = 16'hA17A; foreign[5] = 16'h2881;
    foreign[6] = 16'h8123; foreign[7] = 16'h3456; foreign[8] = 16'h5ABC;
    foreign[9] = 16'h2C9A;
    for (int r = 0; r < 8; r++) mreg[r] = 16'h0;
    mc = 1'b0;
    mres = 16'h0;

    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    compare("R1");
    for (int r = 0; r < 8; r++) readback(r, "R1");

    // Carry corners
    do_li(1, 8'hFF); do_lis(1, 8'hFF);
    do_li(2, 8'h01);
    do_rr(2, 3, 1, 2);
    do_rr(3, 4, 2, 1);
    do_rr(3, 5, 1, 1);
    do_rr(0, 6, 1, 2);
    chk("R12", "carry_after_and", int'(carry_flag), 1);
    do_addc(7, 1);
    do_addc(7, 2);
    do_imm(2, 0, 1, 0);
    do_imm(3, 0, 2, 0);
    do_imm(3, 0, 2, 1);

    for (int pass = 0; pass < 3; pass++) begin
      seed(pass * 977 + 5);
      for (int op = 0; op < 4; op++)
        for (int l = 0; l < 8; l++)
          for (int r = 0; r < 8; r++)
            do_rr(op, (l + r + op) % 8, l, r);
      seed(pass * 311 + 17);
      for (int op = 0; op < 4; op++) begin
        if (op == 1) continue;
        for (int k = 0; k < 8; k++)
          for (int l = 0; l < 8; l++)
            do_imm(op, (k + l) % 8, l, k);
      end
      seed(pass * 53 + 29);
      for (int dir = 0; dir < 2; dir++)
        for (int amt = 0; amt < 16; amt++)
          for (int l = 0; l < 8; l++) begin
            do_shift(dir, (l + 1) % 8, l, amt);
            if (l == 7) do_li(l, (amt * 37 + dir) & 255);
          end
      for (int s = 0; s < 8; s++) do_not((s + 3) % 8, s);
      for (int s = 0; s < 8; s++) do_addc(s, (s + 5) % 8);
      for (int v = 0; v < 256; v += 17) begin
        do_li(v % 8, v);
        do_lis((v + 1) % 8, 255 - v);
      end
    end

    // Foreign encodings must not disturb anything
    do_li(4, 8'h00);
    do_imm(3, 5, 4, 0);
    for (int i = 0; i < 10; i++) issue(foreign[i], "R11");
    do_li(0, 8'h80); do_lis(0, 8'h80);
    for (int i = 0; i < 10; i++) issue(foreign[i], "R11");
    for (int r = 0; r < 8; r++) readback(r, "R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule